// File: doc/BRIEF.md
# Prescaled Reloadable Event Counter

This block divides an incoming clock-enable tick by a programmable ratio and counts the divided events. A down-counting divider steps once per tick. One tick after it reaches zero it takes its start value again from a software-set reload register. On that same tick a wide up-counter advances by one. When the reload value is zero, the divider stays at zero and the up-counter advances on every tick.

Software can read and write all three values: the reload value, the live divider count and the event count. Each has its own write strobe and all three share one data bus. A write takes effect on the next rising clock edge. If a tick arrives in the same cycle, the write takes priority for the register being written. The tick itself is an input, typically a 20 MHz enable, and is generated elsewhere. Address decoding is also done outside the block.

Top module: `ev_prescale_counter`

## Requirements
- R1: While rst_n is low, at each rising edge reload_val, div_val and count_val become zero.
- R2: On a tick with no divider write, a nonzero div_val decreases by exactly one. count_val is unchanged unless it is written.
- R3: On a tick with no divider write, a div_val of zero takes the reload_val held before that edge. On the same edge count_val increases by one, unless count_val is being written.
- R4: With reload_val zero, div_val stays at zero once there, and count_val increases on every tick.
- R5: In a cycle with no tick and no divider or count write, div_val and count_val keep their values.
- R6: A wr_reload strobe loads wr_data into reload_val at the next edge. It does not alter div_val. Without the strobe, reload_val holds.
- R7: A wr_div strobe loads wr_data into div_val at the next edge, even when a tick arrives in the same cycle. The loaded value may exceed reload_val. count_val still follows the tick using the old div_val.
- R8: A wr_count strobe loads wr_data into count_val at the next edge, even when a tick arrives in the same cycle. Later increments continue from the loaded value.
- R9: count_val wraps from all ones to zero and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescale tick enable, one cycle per tick |
| wr_reload | input | 1 | Write strobe for the reload value |
| wr_div | input | 1 | Write strobe for the live divider count |
| wr_count | input | 1 | Write strobe for the event count |
| wr_data | input | DATA_W (32) | Write data shared by the three strobes |
| reload_val | output | DIV_W (32) | Current reload value |
| div_val | output | DIV_W (32) | Current divider count |
| count_val | output | CNT_W (32) | Current event count |

## Verification
All state is visible at the ports, one register away from its inputs. A wrong decrement or reload therefore shows up in div_val on the edge right after the faulty tick. If the reload lands one tick early or late, or the divider fails to stick at zero for a zero reload, count_val advances on the wrong tick. That error persists as a permanent offset, so every later count read is wrong. The bench walks the divide-by-six example sequence, the zero-reload mode and the all-ones wrap. It also checks that a write beats a tick arriving in the same cycle.

// File: rtl/ev_prescale_pkg.sv
// Shared types for the prescaled event counter.
package ev_prescale_pkg;
    // Next-state action chosen for the divider register.
    typedef enum logic [1:0] {
        DIV_HOLD   = 2'd0,
        DIV_DEC    = 2'd1,
        DIV_RELOAD = 2'd2,
        DIV_LOAD   = 2'd3
    } div_act_e;
endpackage

// File: rtl/ev_reload_reg.sv
// Reload value register. Assumes the strobe is one cycle wide.
module ev_reload_reg #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_val,
    output logic [DIV_W-1:0] val_q
);
    // Load on write, clear on reset, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     val_q <= '0;
        else if (wr_en) val_q <= wr_val;
    end
endmodule

// File: rtl/ev_divider.sv
// Down-counting divider. It decrements on each tick while nonzero.
// On the tick after it reads zero it reloads. A write beats a tick.
// roll flags the tick at which it reloads, or sticks at zero when the
// reload value is zero.
module ev_divider
    import ev_prescale_pkg::*;
#(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_val,
    input  logic [DIV_W-1:0] reload_val,
    output logic [DIV_W-1:0] cnt_q,
    output logic             roll
);
    div_act_e act;
    logic     at_zero;

    // Choose this cycle's action, with the write taking priority.
    always_comb begin
        at_zero = (cnt_q == '0);
        if (wr_en)        act = DIV_LOAD;
        else if (!tick_en) act = DIV_HOLD;
        else if (at_zero)  act = DIV_RELOAD;
        else               act = DIV_DEC;
    end

    // The event is raised by the tick on the old count, regardless of any write.
    assign roll = tick_en && at_zero;

    // Apply the chosen action to the divider register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else begin
            unique case (act)
                DIV_LOAD:   cnt_q <= wr_val;
                DIV_RELOAD: cnt_q <= reload_val;
                DIV_DEC:    cnt_q <= cnt_q - 1'b1;
                default:    cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/ev_upcount.sv
// Event up-counter. It advances on each divider roll and wraps silently.
// A write beats an increment in the same cycle.
module ev_upcount #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    // Load, increment modulo 2^CNT_W, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (wr_en) cnt_q <= wr_val;
        else if (inc)   cnt_q <= cnt_q + STEP;
    end
endmodule

// File: rtl/ev_prescale_counter.sv
// Prescaled reloadable event counter, top level.
// Assumes tick_en is a one-cycle enable in the clk domain, and that the
// address decode producing the write strobes lives outside this block.
// Requires DIV_W <= DATA_W and CNT_W <= DATA_W.
module ev_prescale_counter #(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_reload,
    input  logic              wr_div,
    input  logic              wr_count,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DIV_W-1:0]  reload_val,
    output logic [DIV_W-1:0]  div_val,
    output logic [CNT_W-1:0]  count_val
);
    localparam int DIV_MSB = DIV_W - 1;
    localparam int CNT_MSB = CNT_W - 1;

    logic roll;

    ev_reload_reg #(.DIV_W(DIV_W)) u_reload (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_reload),
        .wr_val(wr_data[DIV_MSB:0]), .val_q(reload_val)
    );

    ev_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_div),
        .wr_val(wr_data[DIV_MSB:0]), .reload_val(reload_val),
        .cnt_q(div_val), .roll(roll)
    );

    ev_upcount #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(roll), .wr_en(wr_count),
        .wr_val(wr_data[CNT_MSB:0]), .cnt_q(count_val)
    );
endmodule

// File: rtl/ev_prescale_counter_chk.sv
// Port-level property checker for ev_prescale_counter, bound to every instance.
module ev_prescale_counter_chk #(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_reload,
    input logic              wr_div,
    input logic              wr_count,
    input logic [DATA_W-1:0] wr_data,
    input logic [DIV_W-1:0]  reload_val,
    input logic [DIV_W-1:0]  div_val,
    input logic [CNT_W-1:0]  count_val
);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
    localparam logic [DIV_W-1:0] ONE_D = DIV_W'(1);

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (reload_val == '0 && div_val == '0 && count_val == '0));

    assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_div && div_val != '0) |=> div_val == $past(div_val) - ONE_D);

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_div && div_val == '0) |=> div_val == $past(reload_val));

    assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_count && div_val == '0) |=> count_val == $past(count_val) + ONE_C);

    assert_stick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_div && !wr_reload && div_val == '0 && reload_val == '0)
        |=> (div_val == '0 && reload_val == '0));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_div && !wr_count) |=> ($stable(div_val) && $stable(count_val)));

    assert_reload_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reload |=> reload_val == $past(wr_data[DIV_W-1:0]));

    assert_reload_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_reload |=> $stable(reload_val));

    assert_div_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_div |=> div_val == $past(wr_data[DIV_W-1:0]));

    assert_cnt_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> count_val == $past(wr_data[CNT_W-1:0]));

    assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_count && div_val == '0 && count_val == '1) |=> count_val == '0);
endmodule

bind ev_prescale_counter ev_prescale_counter_chk #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/ev_prescale_counter_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module ev_prescale_counter_bench;
    localparam int W = 32;
    localparam int NV = 33;

    typedef struct packed {
        logic         tick;
        logic         wr_r;
        logic         wr_d;
        logic         wr_c;
        logic [W-1:0] data;
        logic [W-1:0] exp_r;
        logic [W-1:0] exp_d;
        logic [W-1:0] exp_c;
        logic [3:0]   req;
    } vec_t;

    // Fields: tick, wr_reload, wr_div, wr_count, data, expected reload, div, count, requirement.
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b0,1'b0, 32'd5,          32'd5, 32'd0, 32'd0,          4'd6},
        '{1'b0,1'b0,1'b1,1'b0, 32'd7,          32'd5, 32'd7, 32'd0,          4'd7},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd5, 32'd6, 32'd0,          4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd5, 32'd5, 32'd0,          4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd5, 32'd4, 32'd0,          4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd5, 32'd3, 32'd0,          4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd5, 32'd2, 32'd0,          4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd5, 32'd1, 32'd0,          4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd5, 32'd0, 32'd0,          4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd5, 32'd5, 32'd1,          4'd3},
        '{1'b0,1'b0,1'b0,1'b0, 32'd0,          32'd5, 32'd5, 32'd1,          4'd5},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd5, 32'd4, 32'd1,          4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd5, 32'd3, 32'd1,          4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd5, 32'd2, 32'd1,          4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd5, 32'd1, 32'd1,          4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd5, 32'd0, 32'd1,          4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd5, 32'd5, 32'd2,          4'd3},
        '{1'b0,1'b0,1'b0,1'b1, 32'hFFFF_FFFE,  32'd5, 32'd5, 32'hFFFF_FFFE,  4'd8},
        '{1'b1,1'b1,1'b0,1'b0, 32'd0,          32'd0, 32'd4, 32'hFFFF_FFFE,  4'd6},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd0, 32'd3, 32'hFFFF_FFFE,  4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd0, 32'd2, 32'hFFFF_FFFE,  4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd0, 32'd1, 32'hFFFF_FFFE,  4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd0, 32'd0, 32'hFFFF_FFFE,  4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd0, 32'd0, 32'hFFFF_FFFF,  4'd4},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd0, 32'd0, 32'd0,          4'd9},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd0, 32'd0, 32'd1,          4'd4},
        '{1'b1,1'b0,1'b1,1'b0, 32'd3,          32'd0, 32'd3, 32'd2,          4'd7},
        '{1'b1,1'b0,1'b0,1'b1, 32'd100,        32'd0, 32'd2, 32'd100,        4'd8},
        '{1'b1,1'b1,1'b0,1'b0, 32'd9,          32'd9, 32'd1, 32'd100,        4'd6},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd9, 32'd0, 32'd100,        4'd2},
        '{1'b1,1'b1,1'b0,1'b0, 32'd2,          32'd2, 32'd9, 32'd101,        4'd3},
        '{1'b0,1'b0,1'b1,1'b0, 32'd0,          32'd2, 32'd0, 32'd101,        4'd7},
        '{1'b1,1'b0,1'b0,1'b0, 32'd0,          32'd2, 32'd2, 32'd102,        4'd3}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         wr_reload = 1'b0;
    logic         wr_div = 1'b0;
    logic         wr_count = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] reload_val;
    logic [W-1:0] div_val;
    logic [W-1:0] count_val;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    ev_prescale_counter u_ev_prescale_counter (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_reload(wr_reload),
        .wr_div(wr_div), .wr_count(wr_count), .wr_data(wr_data),
        .reload_val(reload_val), .div_val(div_val), .count_val(count_val)
    );

    function automatic string req_name(input logic [3:0] id);
        case (id)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge; sample 2 ns after the next rising edge.
    task automatic step(input logic t, input logic r, input logic d, input logic c,
                        input logic [W-1:0] data);
        @(negedge clk);
        tick_en = t; wr_reload = r; wr_div = d; wr_count = c; wr_data = data;
        @(posedge clk);
        #2;
        tick_en = 1'b0; wr_reload = 1'b0; wr_div = 1'b0; wr_count = 1'b0;
    endtask

    task automatic check_all(input string req, input logic [W-1:0] er,
                             input logic [W-1:0] ed, input logic [W-1:0] ec);
        check(req, "reload_val", reload_val, er);
        check(req, "div_val", div_val, ed);
        check(req, "count_val", count_val, ec);
    endtask

    initial begin
        // R1: reset clears everything, even with a tick present.
        rst_n = 1'b0;
        step(1'b1, 1'b0, 1'b0, 1'b0, '0);
        step(1'b1, 1'b0, 1'b0, 1'b0, '0);
        check_all("R1", '0, '0, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: divide-by-six sequence, zero reload, wrap, write priority.
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].tick, VECS[i].wr_r, VECS[i].wr_d, VECS[i].wr_c, VECS[i].data);
            check_all(req_name(VECS[i].req), VECS[i].exp_r, VECS[i].exp_d, VECS[i].exp_c);
        end

        // R5: idle cycles leave all state untouched.
        step(1'b0, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF);
        step(1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5678);
        check_all("R5", 32'd2, 32'd2, 32'd102);

        // R9: wrap from all ones on a roll with a nonzero reload.
        step(1'b0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF);
        step(1'b0, 1'b0, 1'b1, 1'b0, 32'd0);
        check_all("R8", 32'd2, 32'd0, 32'hFFFF_FFFF);
        step(1'b1, 1'b0, 1'b0, 1'b0, '0);
        check_all("R9", 32'd2, 32'd2, 32'd0);

        // R1: mid-run reset clears nonzero state.
        @(negedge clk);
        rst_n = 1'b0;
        step(1'b1, 1'b0, 1'b0, 1'b0, '0);
        check_all("R1", '0, '0, '0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule